// File: doc/BRIEF.md
# Serial BCH(15,5) Triple-Error-Correcting Encoder

This block turns a 5-bit parallel message into a 15-bit systematic codeword of the binary BCH code with length 15 and dimension 5. The code corrects up to three bit errors. The codeword leaves the block one bit per clock, highest-order coefficient first. First come the five message bits unchanged, then the ten check bits.

The check bits come from a 10-stage linear feedback shift register. Its taps are set by the generator polynomial g(x) = x^10 + x^8 + x^5 + x^4 + x^2 + x + 1, held as the parameter value 11'h537 with bit i giving the coefficient of x^i. A small sequencer runs two phases:

- In the message phase, each message bit goes to the output and into the register feedback.
- In the parity phase, the feedback is cut and the register contents shift out.

A start strobe with a message begins one codeword. Strobes that arrive while a codeword is still being sent are dropped.

Top module: `bch15_enc`

## Requirements
- R1: While rst_ni is low, valid_o, done_o and code_o are all 0.
- R2: A start_i seen high at a clock edge while valid_o is low is accepted. valid_o is then high for exactly 15 consecutive cycles, beginning in the cycle after that edge, and then falls.
- R3: The first five valid bits are the message bits, msg_i[4] first and msg_i[0] last. The message is the one sampled at the accepting edge.
- R4: The last ten valid bits are the remainder of x^10·m(x) divided by g(x), coefficient of x^9 first. Here m(x) has msg_i[i] as the coefficient of x^i, and g(x) = 1 + x + x^2 + x^4 + x^5 + x^8 + x^10. The full stream is therefore the 15-bit word {m, remainder} sent MSB first. For example, message 5'b00001 gives 15'h0537.
- R5: done_o is high for exactly one cycle per codeword, in the cycle of the 15th valid bit.
- R6: A start_i while valid_o is high is ignored, including during the 15th bit. The stream in progress is unchanged, and no new codeword follows.
- R7: The parity register is cleared at every accepted start. Each codeword therefore depends only on its own message, whatever was encoded before it.
- R8: The all-zero message produces fifteen zero bits.
- R9: code_o is 0 whenever valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a codeword; honoured only while idle |
| msg_i | input | 5 | Message, sampled at the accepting edge |
| code_o | output | 1 | Serial codeword bit |
| valid_o | output | 1 | code_o carries a codeword bit |
| done_o | output | 1 | Final (15th) bit of the codeword |

## Verification
The stream is compared with a reference polynomial division for four kinds of message, each of which exposes a different class of fault:

- The all-zero message shows whether the register clears and whether stray feedback is present.
- The single-one message 00001 reproduces g(x) itself, so a wrong tap shows up directly.
- The all-ones message and a sample taken from a real codeword drive feedback in every message cycle.
- Seeded random messages cover the remaining combinations.

Start strobes placed in the middle of a word and on its final bit check that busy-time requests are dropped. An all-ones word followed directly by a zero word checks that no parity state carries over between codewords. A reset applied mid-word checks that the outputs return to 0 at once.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  localparam int unsigned CODE_N = 15;
  localparam int unsigned MSG_K  = 5;
  localparam logic [10:0] GEN_POLY = 11'h537;  // bit i = coeff of x^i

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MSG  = 2'd1,
    PH_PAR  = 2'd2
  } enc_phase_e;
endpackage

// File: rtl/bch_enc_seq.sv
module bch_enc_seq
  import bch_enc_pkg::*;
#(
  parameter int unsigned N_P   = CODE_N,
  parameter int unsigned K_P   = MSG_K,
  localparam int unsigned CNT_W = $clog2(N_P + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       accept_o,
  output enc_phase_e phase_o,
  output logic       last_o
);
  enc_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i && (phase_q == PH_IDLE);
  assign phase_o  = phase_q;
  assign last_o   = (phase_q == PH_PAR) && (cnt_q == CNT_W'(N_P - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept_o) begin
          phase_q <= PH_MSG;
          cnt_q   <= '0;
        end
        PH_MSG: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(K_P - 1)) phase_q <= PH_PAR;
        end
        PH_PAR: begin
          if (last_o) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_msg_sreg.sv
module bch_msg_sreg #(
  parameter int unsigned K_P = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic [K_P-1:0] msg_i,
  output logic           bit_o
);
  logic [K_P-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= msg_i;
    else if (shift_i) sr_q <= {sr_q[K_P-2:0], 1'b0};
  end

  assign bit_o = sr_q[K_P-1];
endmodule

// File: rtl/bch_parity_lfsr.sv
module bch_parity_lfsr #(
  parameter int unsigned PAR_W = 10,
  parameter logic [PAR_W:0] GEN_P = 11'h537
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic feed_i,   // switch closed: divide
  input  logic drain_i,  // switch open: shift out
  input  logic din_i,
  output logic par_o
);
  logic [PAR_W-1:0] par_q, div_nxt;
  logic             fb;

  assign fb = din_i ^ par_q[PAR_W-1];

  for (genvar g = 0; g < PAR_W; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign div_nxt[g] = fb;
    end else begin : g_rest
      assign div_nxt[g] = par_q[g-1] ^ (GEN_P[g] & fb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      par_q <= '0;
    else if (clear_i) par_q <= '0;
    else if (feed_i)  par_q <= div_nxt;
    else if (drain_i) par_q <= {par_q[PAR_W-2:0], 1'b0};
  end

  assign par_o = par_q[PAR_W-1];
endmodule

// File: rtl/bch15_enc.sv
module bch15_enc
  import bch_enc_pkg::*;
#(
  parameter int unsigned N_P = CODE_N,
  parameter int unsigned K_P = MSG_K,
  parameter logic [N_P-K_P:0] GEN_P = GEN_POLY
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [K_P-1:0] msg_i,
  output logic           code_o,
  output logic           valid_o,
  output logic           done_o
);
  localparam int unsigned PAR_W = N_P - K_P;

  enc_phase_e phase;
  logic       accept, last, msg_bit, par_bit, in_msg, in_par;

  bch_enc_seq #(.N_P(N_P), .K_P(K_P)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .phase_o (phase),
    .last_o  (last)
  );

  assign in_msg = (phase == PH_MSG);
  assign in_par = (phase == PH_PAR);

  bch_msg_sreg #(.K_P(K_P)) u_msg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .shift_i(in_msg),
    .msg_i  (msg_i),
    .bit_o  (msg_bit)
  );

  bch_parity_lfsr #(.PAR_W(PAR_W), .GEN_P(GEN_P)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .feed_i (in_msg),
    .drain_i(in_par),
    .din_i  (msg_bit),
    .par_o  (par_bit)
  );

  // output switch
  always_comb begin
    code_o = 1'b0;
    if (in_msg)      code_o = msg_bit;
    else if (in_par) code_o = par_bit;
  end

  assign valid_o = in_msg || in_par;
  assign done_o  = last;
endmodule

// File: rtl/bch15_enc_chk.sv
module bch15_enc_chk #(
  parameter int unsigned N_P = 15,
  parameter int unsigned K_P = 5,
  localparam int unsigned CNT_W = $clog2(N_P + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [K_P-1:0] msg_i,
  input logic           code_o,
  input logic           valid_o,
  input logic           done_o
);
  logic [CNT_W-1:0] run_q;
  logic [K_P-1:0]   lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lat_q <= '0;
    end else begin
      run_q <= valid_o ? run_q + 1'b1 : '0;
      if (start_i && !valid_o) lat_q <= msg_i;
      else if (valid_o)        lat_q <= {lat_q[K_P-2:0], 1'b0};
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !done_o && !code_o));

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o) |=> valid_o);

  p_run_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (run_q < CNT_W'(N_P)));

  p_run_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> (run_q == CNT_W'(N_P)));

  p_msg_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && run_q < CNT_W'(K_P)) |-> (code_o == lat_q[K_P-1]));

  p_done_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_o && run_q == CNT_W'(N_P - 1)));

  p_done_due_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && run_q == CNT_W'(N_P - 1)) |-> done_o);

  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o) |=> (valid_o && run_q == $past(run_q) + 1'b1));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !code_o);
endmodule

bind bch15_enc bch15_enc_chk #(.N_P(N_P), .K_P(K_P)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .msg_i  (msg_i),
  .code_o (code_o),
  .valid_o(valid_o),
  .done_o (done_o)
);

// File: tb/bch15_enc_bench.sv
`timescale 1ns/1ps
module bch15_enc_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] msg_i = '0;
  logic       code_o, valid_o, done_o;

  int unsigned n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk_i = ~clk_i;

  bch15_enc u_bch15_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .msg_i(msg_i),
    .code_o(code_o), .valid_o(valid_o), .done_o(done_o)
  );

  function automatic logic [14:0] ref_code(input logic [4:0] m);
    logic [14:0] r;
    r = {m, 10'b0};
    for (int b = 14; b >= 10; b--)
      if (r[b]) r = r ^ (15'(11'h537) << (b - 10));
    return {m, r[9:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // poke_mid: start during bit 7; poke_end: start during bit 15
  task automatic run_word(input logic [4:0] m, input bit poke_mid, input bit poke_end);
    logic [14:0] got, exp;
    bit          vbad, dbad;
    got = '0; vbad = 0; dbad = 0;
    exp = ref_code(m);
    @(negedge clk_i);
    start_i = 1'b1; msg_i = m;
    @(negedge clk_i);
    start_i = 1'b0; msg_i = 5'($urandom);
    for (int i = 0; i < 15; i++) begin
      if (valid_o !== 1'b1) vbad = 1;
      got = {got[13:0], code_o};
      if (done_o !== (i == 14)) dbad = 1;
      start_i = (poke_mid && i == 6) || (poke_end && i == 14);
      if (start_i) msg_i = ~m;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(got[14:10] == m, "R3", "message bits", 32'(got[14:10]), 32'(m));
    check(got[9:0] == exp[9:0], "R4", "parity bits", 32'(got[9:0]), 32'(exp[9:0]));
    check(!vbad, "R2", "valid run of 15", 32'(vbad), 0);
    check(!dbad, "R5", "done on 15th bit only", 32'(dbad), 0);
    check(valid_o == 1'b0, poke_end ? "R6" : "R2", "valid low after word",
          32'(valid_o), 0);
    check(code_o == 1'b0, "R9", "code low when idle", 32'(code_o), 0);
    if (poke_mid)
      check(got == exp, "R6", "mid-word start ignored", 32'(got), 32'(exp));
  endtask

  initial begin
    void'($urandom(32'd1517));
    #1;
    check(!valid_o && !done_o && !code_o, "R1", "outputs in reset",
          {29'd0, valid_o, done_o, code_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!valid_o && !code_o, "R9", "idle after reset", {30'd0, valid_o, code_o}, 0);

    check(ref_code(5'b00001) == 15'h0537, "R4", "reference g(x)",
          32'(ref_code(5'b00001)), 32'h0537);
    run_word(5'b00000, 0, 0);                 // R8
    run_word(5'b00001, 0, 0);                 // R4 single tap pattern
    run_word(5'b11111, 0, 0);
    run_word(5'b10011, 1, 0);                 // R6 mid
    run_word(5'b01010, 0, 1);                 // R6 end
    run_word(5'b11111, 0, 0);                 // R7 then zero
    run_word(5'b00000, 0, 0);                 // R7, R8
    for (int n = 0; n < 40; n++)
      run_word(5'($urandom), n[2], n[3] && n[0]);

    // R1: reset in mid-word
    @(negedge clk_i);
    start_i = 1'b1; msg_i = 5'b11111;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(!valid_o && !done_o && !code_o, "R1", "mid-word reset",
          {29'd0, valid_o, done_o, code_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_word(5'b10110, 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule